// File: doc/BRIEF.md
# Hash accelerator register front-end

This block is the register and control shell around a SHA-1/MD5 compression engine. Software reaches it through a word-addressed register bus. Through that bus it can set or restore the five-word digest context and the processed-byte count, and it programs a chunk with a byte length and three flags: algorithm, load initial constants and close hash. Once a chunk is armed, the block raises input-ready. It then gathers sixteen 32-bit words for each 64-byte block, either from processor writes into the data-in window or from a DMA burst port, and passes each full block to the compression core.

Each block result is folded back into the digest. The byte count grows by the bytes that block accounts for, and input-ready rises again until the chunk length is used up. At that point output-ready is set, and an active-low level interrupt follows if interrupts are enabled. Because the context can be read back and rewritten while the block is idle, several messages can share the engine chunk by chunk. The compression rounds are represented by a fixed-latency stub, and message padding is not part of this block.

Top module: `hash_fe_top`

## Requirements
- R1: After reset, every readable register reads zero, except status (word 25), which reads 1, and revision. `irq_n` is 1 and `dma_req` is 0.
- R2: Control is word 6, laid out as {length[26:0], close[4], load-IV[3], sha1[2], input-ready[1], output-ready[0]}. While idle, a control write stores all three flags and the length. A nonzero length sets input-ready at the next edge, and a zero length leaves it clear.
- R3: A control write made while idle with bit 3 set loads the initial constants 67452301, EFCDAB89, 98BADCFE, 10325476 into digest words 0 to 3. Digest word 4 becomes C3D2E1F0 when bit 2 selects SHA-1, or 0 for MD5. The byte count (word 5) is cleared.
- R4: Digest words (0 to 4) and the byte count (5) can be written and read while idle. Writes to them are ignored while a chunk is in progress.
- R5: Accepted data words fill block slots 0 to 15 in arrival order, whichever data-in word (7 to 22) is addressed. The 16th word clears input-ready at the same edge. LAT+1 edges later, each digest word i gains (b[i] ^ b[i+5] ^ b[i+10] ^ b[15]), added modulo 2^32.
- R6: Each completed block adds min(64, remaining length) to the byte count. If length remains, input-ready rises again. Otherwise output-ready is set.
- R7: A control write with bit 0 set clears output-ready. With bit 0 clear, output-ready is left as it is.
- R8: `irq_n` is low exactly when output-ready and the interrupt enable (config word 24, bit 2) are both set.
- R9: When the sha1 flag is clear (MD5), digest words are byte-swapped on both read and write. With SHA-1 they pass through unchanged.
- R10: `dma_req` is asserted while the DMA enable (config bit 3) and input-ready are both set. A DMA word is taken only while `dma_req` is high, and `dma_req` drops after the 16th word of a burst.
- R11: Writing config bit 1 makes status bit 0 read 0 for one cycle. At the next edge all control, digest, count and config state returns to its reset value, and status reads 1 again.
- R12: Data-in writes while input-ready is clear are ignored and take no block slot.
- R13: The revision register (word 23) reads {major[7:4], minor[3:0]}, which is 0x21 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 5 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| dma_valid | input | 1 | DMA word present |
| dma_wdata | input | 32 | DMA word |
| dma_req | output | 1 | DMA burst request |
| irq_n | output | 1 | Level interrupt, active low |

## Verification
A wrong word counter or state shows up within one cycle as a misplaced fall of `dma_req` or of the input-ready bit. It also surfaces LAT+1 cycles after the final word, as a digest readback that mixes the wrong slots. A wrong remaining-length value appears at the next block completion, either as a byte count that differs or as output-ready and `irq_n` changing a block early or late. The bench compares the register under the current address, `dma_req` and `irq_n` against a behavioural model after every edge, so any such divergence is reported in the cycle in which it first becomes visible.

// File: rtl/hash_fe_pkg.sv
package hash_fe_pkg;
    typedef logic [31:0] word_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_CRUNCH = 2'd2
    } fe_state_e;

    localparam int DIG_WORDS = 5;
    localparam int BLK_WORDS = 16;
    localparam int LEN_W     = 27;

    // register word indices
    localparam int A_CNT  = DIG_WORDS;
    localparam int A_CTRL = A_CNT + 1;
    localparam int A_DIN  = A_CTRL + 1;
    localparam int A_REV  = A_DIN + BLK_WORDS;
    localparam int A_CFG  = A_REV + 1;
    localparam int A_STAT = A_CFG + 1;

    function automatic word_t bswap(input word_t w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic word_t iv_word(input int i, input logic sha1);
        case (i)
            0:       return 32'h67452301;
            1:       return 32'hEFCDAB89;
            2:       return 32'h98BADCFE;
            3:       return 32'h10325476;
            4:       return sha1 ? 32'hC3D2E1F0 : 32'h0;
            default: return 32'h0;
        endcase
    endfunction
endpackage

// File: rtl/hash_fe_blkbuf.sv
module hash_fe_blkbuf
    import hash_fe_pkg::*;
#(
    parameter int WORDS = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [$clog2(WORDS)-1:0]   idx,
    input  word_t                      wdata,
    output word_t [WORDS-1:0]          blk
);
    localparam int IDX_W = $clog2(WORDS);

    for (genvar g = 0; g < WORDS; g++) begin : g_slot
        word_t slot_d, slot_q;
        always_comb slot_d = (we && idx == IDX_W'(g)) ? wdata : slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q <= '0;
            else        slot_q <= slot_d;
        end
        assign blk[g] = slot_q;
    end
endmodule

// File: rtl/hash_fe_core_stub.sv
module hash_fe_core_stub
    import hash_fe_pkg::*;
#(
    parameter int LAT    = 4,
    parameter int DWORDS = 5,
    parameter int BWORDS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  word_t [DWORDS-1:0]    state_i,
    input  word_t [BWORDS-1:0]    blk_i,
    output logic                  done_o,
    output word_t [DWORDS-1:0]    res_o
);
    localparam int CNT_W = $clog2(LAT) + 1;

    typedef struct packed {
        logic               busy;
        logic [CNT_W-1:0]   cnt;
        word_t [DWORDS-1:0] res;
    } stub_t;

    stub_t r_q, r_d;
    word_t [DWORDS-1:0] fold;

    for (genvar g = 0; g < DWORDS; g++) begin : g_fold
        assign fold[g] = blk_i[g] ^ blk_i[g + 5] ^ blk_i[g + 10] ^ blk_i[BWORDS - 1];
    end

    assign done_o = r_q.busy && (r_q.cnt == '0);
    assign res_o  = r_q.res;

    always_comb begin
        r_d = r_q;
        if (start_i) begin
            r_d.busy = 1'b1;
            r_d.cnt  = CNT_W'(LAT - 1);
            for (int i = 0; i < DWORDS; i++) r_d.res[i] = state_i[i] + fold[i];
        end else if (done_o) begin
            r_d.busy = 1'b0;
        end else if (r_q.busy) begin
            r_d.cnt = r_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assert_no_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !r_q.busy)
        else $error("block launched while core still busy");
endmodule

// File: rtl/hash_fe_ctrl.sv
module hash_fe_ctrl
    import hash_fe_pkg::*;
#(
    parameter int DIG_W = 5,
    parameter int BLK_W = 16,
    parameter int LN_W  = 27
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_dig,
    input  logic [2:0]                 dig_idx,
    input  logic                       wr_cnt,
    input  logic                       wr_ctrl,
    input  logic                       wr_cfg,
    input  logic                       din_wr,
    input  word_t                      wdata,
    input  logic                       dma_valid,
    input  word_t                      dma_wdata,
    input  logic                       core_done,
    input  word_t [DIG_W-1:0]          core_res,
    output word_t [DIG_W-1:0]          dig_o,
    output word_t                      cnt_o,
    output word_t                      ctrl_o,
    output logic [3:0]                 cfg_o,
    output logic                       reset_done_o,
    output logic                       sha1_o,
    output logic                       buf_we,
    output logic [$clog2(BLK_W)-1:0]   buf_idx,
    output word_t                      buf_wdata,
    output logic                       core_start,
    output logic                       dma_req
);
    localparam int WC_W  = $clog2(BLK_W);
    localparam int BLK_B = BLK_W * 4;

    typedef struct packed {
        fe_state_e         st;
        logic [WC_W-1:0]   wcnt;
        logic              kick;
        logic [LN_W-1:0]   rem;
        logic [LN_W-1:0]   len;
        logic              close, ldc, alg, in_rdy, out_rdy;
        logic              autoidle, irqen, dmaen, pend;
        word_t             cnt;
        word_t [DIG_W-1:0] dig;
    } regs_t;

    regs_t r_q, r_d;
    logic accept;
    logic [LN_W-1:0] step;

    assign accept = r_q.in_rdy && (din_wr || (dma_valid && r_q.dmaen));
    assign step   = (r_q.rem > LN_W'(BLK_B)) ? LN_W'(BLK_B) : r_q.rem;

    always_comb begin
        r_d      = r_q;
        r_d.kick = 1'b0;
        if (r_q.pend) begin
            r_d = '0;
        end else begin
            if (wr_cfg) begin
                r_d.autoidle = wdata[0];
                r_d.pend     = wdata[1];
                r_d.irqen    = wdata[2];
                r_d.dmaen    = wdata[3];
            end
            if (wr_ctrl && wdata[0]) r_d.out_rdy = 1'b0;
            if (r_q.st == ST_IDLE) begin
                for (int i = 0; i < DIG_W; i++)
                    if (wr_dig && dig_idx == 3'(i))
                        r_d.dig[i] = r_q.alg ? wdata : bswap(wdata);
                if (wr_cnt) r_d.cnt = wdata;
                if (wr_ctrl) begin
                    r_d.alg   = wdata[2];
                    r_d.ldc   = wdata[3];
                    r_d.close = wdata[4];
                    r_d.len   = wdata[31:5];
                    if (wdata[3]) begin
                        for (int i = 0; i < DIG_W; i++) r_d.dig[i] = iv_word(i, wdata[2]);
                        r_d.cnt = '0;
                    end
                    if (wdata[31:5] != '0) begin
                        r_d.st     = ST_FILL;
                        r_d.in_rdy = 1'b1;
                        r_d.rem    = wdata[31:5];
                        r_d.wcnt   = '0;
                    end
                end
            end
            if (accept) begin
                r_d.wcnt = r_q.wcnt + 1'b1;
                if (r_q.wcnt == WC_W'(BLK_W - 1)) begin
                    r_d.in_rdy = 1'b0;
                    r_d.st     = ST_CRUNCH;
                    r_d.kick   = 1'b1;
                end
            end
            if (r_q.st == ST_CRUNCH && core_done) begin
                r_d.dig = core_res;
                r_d.cnt = r_q.cnt + 32'(step);
                r_d.rem = r_q.rem - step;
                if (r_q.rem == step) begin
                    r_d.out_rdy = 1'b1;
                    r_d.st      = ST_IDLE;
                end else begin
                    r_d.in_rdy = 1'b1;
                    r_d.st     = ST_FILL;
                    r_d.wcnt   = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign dig_o        = r_q.dig;
    assign cnt_o        = r_q.cnt;
    assign ctrl_o       = {r_q.len, r_q.close, r_q.ldc, r_q.alg, r_q.in_rdy, r_q.out_rdy};
    assign cfg_o        = {r_q.dmaen, r_q.irqen, 1'b0, r_q.autoidle};
    assign reset_done_o = !r_q.pend;
    assign sha1_o       = r_q.alg;
    assign buf_we       = accept;
    assign buf_idx      = r_q.wcnt;
    assign buf_wdata    = din_wr ? wdata : dma_wdata;
    assign core_start   = r_q.kick;
    assign dma_req      = r_q.dmaen && r_q.in_rdy;

    assert_full_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !r_q.pend && r_q.wcnt == WC_W'(BLK_W - 1)) |=> (!r_q.in_rdy && r_q.st == ST_CRUNCH))
        else $error("input-ready still set after sixteenth word");

    assert_burst_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_valid && !r_q.pend && r_q.wcnt == WC_W'(BLK_W - 1)) |=> !dma_req)
        else $error("DMA request held past end of burst");

    assert_done_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.out_rdy) |-> $past(core_done))
        else $error("output-ready raised without core completion");

    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (core_done && r_q.st == ST_CRUNCH && !r_q.pend) |=>
            ((r_q.cnt - $past(r_q.cnt)) != 32'd0 && (r_q.cnt - $past(r_q.cnt)) <= 32'(BLK_B)))
        else $error("byte count step outside one block");

    assert_soft_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.pend |=> (r_q.st == ST_IDLE && !r_q.in_rdy && !r_q.pend))
        else $error("soft reset did not return to idle");
endmodule

// File: rtl/hash_fe_top.sv
module hash_fe_top
    import hash_fe_pkg::*;
#(
    parameter int         LAT       = 4,
    parameter logic [3:0] REV_MAJOR = 4'h2,
    parameter logic [3:0] REV_MINOR = 4'h1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        dma_valid,
    input  logic [31:0] dma_wdata,
    output logic        dma_req,
    output logic        irq_n
);
    localparam int DIN_LO = A_DIN;
    localparam int DIN_HI = A_DIN + BLK_WORDS - 1;
    localparam int IDX_W  = $clog2(BLK_WORDS);

    logic wr_en, wr_dig, wr_cnt, wr_ctrl, wr_cfg, din_wr;
    word_t [DIG_WORDS-1:0] dig;
    word_t [DIG_WORDS-1:0] core_res;
    word_t [BLK_WORDS-1:0] blk;
    word_t cnt, ctrl;
    logic [3:0] cfg;
    logic reset_done, sha1, buf_we, core_start, core_done;
    logic [IDX_W-1:0] buf_idx;
    word_t buf_wdata;

    assign wr_en   = bus_sel && bus_wr;
    assign wr_dig  = wr_en && bus_addr < 5'(DIG_WORDS);
    assign wr_cnt  = wr_en && bus_addr == 5'(A_CNT);
    assign wr_ctrl = wr_en && bus_addr == 5'(A_CTRL);
    assign wr_cfg  = wr_en && bus_addr == 5'(A_CFG);
    assign din_wr  = wr_en && bus_addr >= 5'(DIN_LO) && bus_addr <= 5'(DIN_HI);

    hash_fe_ctrl #(.DIG_W(DIG_WORDS), .BLK_W(BLK_WORDS), .LN_W(LEN_W)) u_ctrl (
        .clk, .rst_n, .wr_dig, .dig_idx(bus_addr[2:0]), .wr_cnt, .wr_ctrl, .wr_cfg,
        .din_wr, .wdata(bus_wdata), .dma_valid, .dma_wdata, .core_done, .core_res,
        .dig_o(dig), .cnt_o(cnt), .ctrl_o(ctrl), .cfg_o(cfg), .reset_done_o(reset_done),
        .sha1_o(sha1), .buf_we, .buf_idx, .buf_wdata, .core_start, .dma_req
    );

    hash_fe_blkbuf #(.WORDS(BLK_WORDS)) u_buf (
        .clk, .rst_n, .we(buf_we), .idx(buf_idx), .wdata(buf_wdata), .blk
    );

    hash_fe_core_stub #(.LAT(LAT), .DWORDS(DIG_WORDS), .BWORDS(BLK_WORDS)) u_core (
        .clk, .rst_n, .start_i(core_start), .state_i(dig), .blk_i(blk),
        .done_o(core_done), .res_o(core_res)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr < 5'(DIG_WORDS))
            bus_rdata = sha1 ? dig[bus_addr[2:0]] : bswap(dig[bus_addr[2:0]]);
        else if (bus_addr == 5'(A_CNT))  bus_rdata = cnt;
        else if (bus_addr == 5'(A_CTRL)) bus_rdata = ctrl;
        else if (bus_addr == 5'(A_REV))  bus_rdata = {24'h0, REV_MAJOR, REV_MINOR};
        else if (bus_addr == 5'(A_CFG))  bus_rdata = {28'h0, cfg};
        else if (bus_addr == 5'(A_STAT)) bus_rdata = {31'h0, reset_done};
    end

    assign irq_n = !(ctrl[0] && cfg[2]);
endmodule

// File: tb/hash_fe_top_test.sv
module hash_fe_top_test;
    localparam int LAT = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_sel = 0, bus_wr = 0, dma_valid = 0;
    logic [4:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, dma_wdata = '0, bus_rdata;
    logic dma_req, irq_n;

    int vectors = 0, miscompares = 0, cyc = 0;
    bit finished = 0;

    // behavioural reference state
    logic [31:0] m_dig [5];
    logic [31:0] m_blk [16];
    logic [31:0] m_cnt;
    int m_len, m_rem, m_st, m_wc, m_tmr;
    bit m_close, m_ldc, m_alg, m_in, m_out, m_auto, m_irqen, m_dmaen, m_pend;

    hash_fe_top #(.LAT(LAT)) uut (.*);

    always #5 clk = ~clk;

    function automatic logic [31:0] sw(logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [31:0] ivw(int i, bit s);
        logic [31:0] t [5] = '{32'h67452301, 32'hEFCDAB89, 32'h98BADCFE, 32'h10325476, 32'hC3D2E1F0};
        return (i == 4 && !s) ? 32'h0 : t[i];
    endfunction

    task automatic clear_model();
        for (int i = 0; i < 5; i++) m_dig[i] = 0;
        m_cnt = 0; m_len = 0; m_rem = 0; m_st = 0; m_wc = 0; m_tmr = 0;
        m_close = 0; m_ldc = 0; m_alg = 0; m_in = 0; m_out = 0;
        m_auto = 0; m_irqen = 0; m_dmaen = 0; m_pend = 0;
    endtask

    function automatic logic [31:0] model_read(int a);
        if (a < 5) return m_alg ? m_dig[a] : sw(m_dig[a]);
        case (a)
            5:  return m_cnt;
            6:  return {m_len[26:0], m_close, m_ldc, m_alg, m_in, m_out};
            23: return 32'h21;
            24: return {28'h0, m_dmaen, m_irqen, 1'b0, m_auto};
            25: return {31'h0, !m_pend};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(int a);
        if (a < 5) return "R3/R4/R5/R9/R12 digest";
        case (a)
            5:  return "R4/R6 bytecount";
            6:  return "R2/R6/R7 control";
            23: return "R13 revision";
            24: return "R1 config";
            25: return "R11 status";
            default: return "R1 unmapped";
        endcase
    endfunction

    task automatic model_step();
        bit wr, din, accept, complete;
        logic [31:0] w, src;
        int st0, step;
        wr = bus_sel && bus_wr;
        w = bus_wdata;
        din = wr && bus_addr >= 7 && bus_addr <= 22;
        accept = m_in && (din || (dma_valid && m_dmaen));
        src = din ? bus_wdata : dma_wdata;
        complete = (m_tmr == 1);
        if (m_tmr > 0) m_tmr--;
        st0 = m_st;
        if (m_pend) begin
            clear_model();
            return;
        end
        if (wr && bus_addr == 24) begin
            m_auto = w[0]; m_pend = w[1]; m_irqen = w[2]; m_dmaen = w[3];
        end
        if (wr && bus_addr == 6 && w[0]) m_out = 0;
        if (st0 == 0) begin
            if (wr && bus_addr < 5) m_dig[bus_addr] = m_alg ? w : sw(w);
            if (wr && bus_addr == 5) m_cnt = w;
            if (wr && bus_addr == 6) begin
                m_alg = w[2]; m_ldc = w[3]; m_close = w[4]; m_len = int'(w[31:5]);
                if (w[3]) begin
                    for (int i = 0; i < 5; i++) m_dig[i] = ivw(i, w[2]);
                    m_cnt = 0;
                end
                if (m_len != 0) begin m_st = 1; m_in = 1; m_rem = m_len; m_wc = 0; end
            end
        end
        if (accept) begin
            m_blk[m_wc] = src;
            if (m_wc == 15) begin m_in = 0; m_st = 2; m_tmr = LAT + 1; m_wc = 0; end
            else m_wc++;
        end
        if (st0 == 2 && complete) begin
            for (int i = 0; i < 5; i++)
                m_dig[i] = m_dig[i] + (m_blk[i] ^ m_blk[i+5] ^ m_blk[i+10] ^ m_blk[15]);
            step = (m_rem > 64) ? 64 : m_rem;
            m_cnt = m_cnt + step;
            m_rem = m_rem - step;
            if (m_rem == 0) begin m_out = 1; m_st = 0; end
            else begin m_in = 1; m_st = 1; m_wc = 0; end
        end
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    task automatic compare_all();
        check(tag_of(int'(bus_addr)), bus_rdata, model_read(int'(bus_addr)));
        check("R8 irq_n", {31'h0, irq_n}, {31'h0, !(m_out && m_irqen)});
        check("R10 dma_req", {31'h0, dma_req}, {31'h0, m_dmaen && m_in});
    endtask

    task automatic cycle();
        model_step();
        @(posedge clk);
        cyc++;
        #1;
        compare_all();
    endtask

    task automatic wr(int a, logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = 5'(a); bus_wdata = d;
        cycle();
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic look(int a);
        bus_addr = 5'(a);
        cycle();
    endtask

    function automatic logic [31:0] ctl(int len, bit cl, bit ld, bit s, bit clr);
        return {len[26:0], cl, ld, s, 1'b0, clr};
    endfunction

    task automatic cpu_block(logic [31:0] seed);
        for (int i = 0; i < 16; i++) wr(7 + (i % 3), seed + 32'h01010101 * i);
    endtask

    task automatic dma_words(int n, logic [31:0] seed);
        dma_valid = 1;
        for (int i = 0; i < n; i++) begin
            dma_wdata = seed ^ (32'h9E3779B9 * (i + 1));
            cycle();
        end
        dma_valid = 0;
    endtask

    task automatic settle(int n);
        for (int i = 0; i < n; i++) look(i % 7);
    endtask

    initial begin
        clear_model();
        for (int i = 0; i < 16; i++) m_blk[i] = 0;
        repeat (2) @(posedge clk);
        #1;
        compare_all();                      // R1 during reset
        rst_n = 1;
        for (int a = 0; a < 28; a++) look(a);   // R1, R13 reset values

        wr(6, ctl(0, 0, 1, 1, 0));          // R3 SHA-1 constants, R2 zero length
        for (int a = 0; a < 7; a++) look(a);
        wr(6, ctl(0, 0, 1, 0, 0));          // R3 MD5 constants, R9 swapped view
        for (int a = 0; a < 6; a++) look(a);
        wr(0, 32'h11223344);                // R4 / R9 write path
        wr(5, 32'h40);
        look(0); look(5);
        wr(7, 32'hDEADBEEF); wr(9, 32'hCAFEF00D);   // R12 stray data while idle

        wr(24, 32'h4);                      // interrupt enable
        wr(6, ctl(100, 1, 1, 1, 0));        // R2 arm 100 bytes SHA-1
        look(6);
        wr(1, 32'h55555555);                // R4 ignored during chunk
        look(1);
        cpu_block(32'h1000);                // R5
        wr(8, 32'hFFFF0000);                // R12 ignored during crunch
        settle(LAT + 3);
        look(5); look(6);                   // R6 first block
        cpu_block(32'h7700_0003);
        settle(LAT + 3);
        for (int a = 0; a < 7; a++) look(a);    // R6 final, R8 irq low

        wr(6, ctl(0, 0, 0, 1, 0));          // R7 bit0 clear keeps output-ready
        look(6);
        wr(6, ctl(0, 0, 0, 1, 1));          // R7 clear
        look(6);

        wr(24, 32'hC);                      // R10 DMA on
        wr(6, ctl(64, 1, 0, 1, 0));
        dma_words(20, 32'hA5A5_0001);
        settle(LAT + 3);
        for (int a = 0; a < 7; a++) look(a);

        wr(24, 32'h4);                      // R10 DMA off: valid ignored
        wr(6, ctl(128, 0, 0, 0, 1));
        dma_words(5, 32'h0BAD_0BAD);
        look(6);
        wr(24, 32'hC);
        dma_words(16, 32'h3C3C_0002);
        settle(LAT + 3);
        dma_words(16, 32'h1234_5678);
        settle(LAT + 3);
        for (int a = 0; a < 7; a++) look(a);
        wr(6, ctl(0, 0, 0, 0, 1));

        wr(6, ctl(64, 0, 1, 1, 0));         // R11 soft reset mid-chunk
        wr(7, 32'h1); wr(7, 32'h2);
        bus_sel = 1; bus_wr = 1; bus_addr = 5'd24; bus_wdata = 32'h2;
        cycle();
        bus_sel = 0; bus_wr = 0;
        look(25); look(25);
        for (int a = 0; a < 7; a++) look(a);
        look(24);
        settle(LAT + 3);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule